// File: doc/BRIEF.md
# Paged SPI EEPROM Word Controller

This block is an SPI master (mode 0: clock idles low, data launched while the clock is low, input sampled on the rising edge) for a byte-addressed serial EEPROM. Toward the host it offers a 16-bit word interface. A one-cycle `start_i` carries a direction, a word offset and a word count. Read words come back one by one with a valid strobe. Write words are taken from `wdata_i` on a capture strobe. The operation ends with a one-cycle done pulse and a sticky error flag.

Before any command, the controller polls the device status register until its busy bit clears, and gives up after a bounded number of polls. Reads use a single command and then stream words, relying on the device's internal address increment. Writes are cut into page bursts. Each burst gets its own ready poll, a write-enable frame and a write command. Byte order inside a word is swapped on the wire in both directions. For devices with 8 address bits, the ninth byte-address bit travels inside the opcode. The SCK rate comes from a divider parameter.

Top module: `spi_ee_ctl`

## Requirements
- R1: After reset, `cs_n_o` is 1, `sck_o` is 0, `mosi_o` is 0, and `done_o` and `err_o` are 0.
- R2: A start with count 0, with offset at or beyond WORDS, or with count greater than WORDS minus offset is rejected. `done_o` pulses with `err_o` set, and chip select never falls.
- R3: Every command sequence begins with a status poll: opcode 0x05 followed by 8 bits read back. While bit 0 of that byte is 1, chip select goes high for GAP_CYC cycles and the poll repeats.
- R4: If POLL_MAX consecutive polls all report busy, the operation ends with `done_o` and `err_o` set. No data word is transferred.
- R5: SCK idles low. MOSI changes only while SCK is low. All fields go out MSB first. MISO is sampled on the rising edge. SCK is high only while chip select is low.
- R6: After the opcode (0x03 for read, 0x02 for write, OP_BITS wide), the byte address, equal to word offset times 2, is shifted out in its low ADDR_BITS bits.
- R7: When ADDR_BITS is 8 and the word offset of the command is 128 or more, bit 3 (mask 0x08) is set in the read or write opcode.
- R8: A read sends one command and then `count` consecutive 16-bit words. Each word is presented on `rdata_o` with a one-cycle `rdata_vld_o`. The first byte received becomes bits 7:0 and the second becomes bits 15:8.
- R9: Each write burst sends the write-enable opcode 0x06 in a chip-select frame of its own, after the status poll and before the write command.
- R10: A write burst ends after a word when the next byte address is a multiple of PAGE_BYTES. If words remain, a new poll, write-enable and write command follow at that address.
- R11: `wr_take_o` is high for exactly the cycle whose closing edge captures `wdata_i`, once per written word. Bits 7:0 of the word go on the wire first.
- R12: An operation ends by raising chip select while SCK is low. `done_o` is then pulsed for one cycle with chip select high, and `err_o` is 0 after a successful operation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | One-cycle request, taken while idle |
| write_i | input | 1 | 1 selects write, 0 selects read |
| offset_i | input | OFS_W | First word offset |
| count_i | input | OFS_W | Number of words |
| wdata_i | input | 16 | Write word, captured while `wr_take_o` is high |
| wr_take_o | output | 1 | Current `wdata_i` is consumed this cycle |
| rdata_o | output | 16 | Read word |
| rdata_vld_o | output | 1 | `rdata_o` holds a new word |
| done_o | output | 1 | Operation finished (one cycle) |
| err_o | output | 1 | Last operation failed (bounds or status timeout) |
| sck_o | output | 1 | Serial clock |
| cs_n_o | output | 1 | Chip select, active low |
| mosi_o | output | 1 | Serial data to the device |
| miso_i | input | 1 | Serial data from the device |

## Verification
The bench runs a behavioural EEPROM model with page-wrapping writes, a write-enable latch, a busy period after each commit, and an address bit taken from the opcode. It sweeps many offset and count pairs, including runs that cross page edges, the 128-word boundary and the end of the array.

A controller that skips page splitting shows up as data wrapping inside a page. One that merges the write-enable frame into the command, or drops it, loses its writes. A wrong A8 bit or a wrong byte swap lands data at the wrong address or in the wrong half of the word. Polling that stops early trips the model's busy-violation counter. Exact poll and burst counts, the stuck-busy timeout count, and all three bounds rejections (confirmed through the absence of chip-select activity) are checked against arithmetic in the bench.

// File: rtl/spi_ee_pkg.sv
package spi_ee_pkg;

    typedef enum logic [3:0] {
        S_IDLE,
        S_POLL_OP,
        S_POLL_IN,
        S_GAP,
        S_WREN,
        S_CMD,
        S_ADDR,
        S_DATA,
        S_FIN
    } ctl_state_e;

    localparam logic [7:0] OPC_READ  = 8'h03;
    localparam logic [7:0] OPC_WRITE = 8'h02;
    localparam logic [7:0] OPC_WREN  = 8'h06;
    localparam logic [7:0] OPC_RDSR  = 8'h05;
    localparam logic [7:0] OPC_A8    = 8'h08;

endpackage

// File: rtl/spi_ee_shift.sv
module spi_ee_shift #(
    parameter int DIV = 4,
    parameter int W   = 16,
    localparam int DW = (DIV > 1) ? $clog2(DIV) : 1,
    localparam int NW = $clog2(W + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          go_i,
    input  logic [NW-1:0] nbits_i,
    input  logic [W-1:0]  tx_i,
    input  logic          miso_i,
    output logic          fin_o,
    output logic [W-1:0]  rx_o,
    output logic          sck_o,
    output logic          mosi_o
);

    typedef struct packed {
        logic          busy;
        logic          ph;
        logic          sck;
        logic          fin;
        logic [DW-1:0] div;
        logic [NW-1:0] left;
        logic [W-1:0]  sh;
        logic [W-1:0]  rx;
    } eng_t;

    eng_t eng_q, eng_d;

    always_comb begin
        eng_d     = eng_q;
        eng_d.fin = 1'b0;
        if (!eng_q.busy) begin
            if (go_i) begin
                eng_d.busy = 1'b1;
                eng_d.ph   = 1'b0;
                eng_d.div  = '0;
                eng_d.left = nbits_i;
                eng_d.sh   = tx_i << (NW'(W) - nbits_i);
                eng_d.rx   = '0;
            end
        end else if (eng_q.div == DW'(DIV - 1)) begin
            eng_d.div = '0;
            if (!eng_q.ph) begin
                eng_d.ph  = 1'b1;
                eng_d.sck = 1'b1;
                eng_d.rx  = {eng_q.rx[W-2:0], miso_i};
            end else begin
                eng_d.ph  = 1'b0;
                eng_d.sck = 1'b0;
                if (eng_q.left == NW'(1)) begin
                    eng_d.busy = 1'b0;
                    eng_d.fin  = 1'b1;
                end else begin
                    eng_d.left = eng_q.left - NW'(1);
                    eng_d.sh   = eng_q.sh << 1;
                end
            end
        end else begin
            eng_d.div = eng_q.div + DW'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) eng_q <= '0;
        else        eng_q <= eng_d;
    end

    assign fin_o  = eng_q.fin;
    assign rx_o   = eng_q.rx;
    assign sck_o  = eng_q.sck;
    assign mosi_o = eng_q.busy ? eng_q.sh[W-1] : 1'b0;

    AST_SCK_ONLY_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sck_o) |-> $past(eng_q.busy)) else $error("sck rose while idle"); // R5

endmodule

// File: rtl/spi_ee_ctl.sv
module spi_ee_ctl
    import spi_ee_pkg::*;
#(
    parameter int WORDS      = 256,
    parameter int ADDR_BITS  = 8,
    parameter int OP_BITS    = 8,
    parameter int PAGE_BYTES = 32,
    parameter int SCK_DIV    = 4,
    parameter int POLL_MAX   = 64,
    parameter int GAP_CYC    = 8,
    localparam int OFS_W     = $clog2(WORDS) + 1,
    localparam int NBW       = $clog2(17),
    localparam int PW_BITS   = $clog2(PAGE_BYTES / 2),
    localparam int TW        = $clog2(POLL_MAX + 1),
    localparam int GW        = $clog2(GAP_CYC + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic             write_i,
    input  logic [OFS_W-1:0] offset_i,
    input  logic [OFS_W-1:0] count_i,
    input  logic [15:0]      wdata_i,
    output logic             wr_take_o,
    output logic [15:0]      rdata_o,
    output logic             rdata_vld_o,
    output logic             done_o,
    output logic             err_o,
    output logic             sck_o,
    output logic             cs_n_o,
    output logic             mosi_o,
    input  logic             miso_i
);

    typedef struct packed {
        ctl_state_e       st;
        ctl_state_e       nxt;
        logic             sent;
        logic             write;
        logic [OFS_W-1:0] ofs;
        logic [OFS_W-1:0] left;
        logic [TW-1:0]    tries;
        logic [GW-1:0]    gap;
        logic             csn;
        logic [15:0]      rdata;
        logic             rvld;
        logic             done;
        logic             err;
    } ctl_t;

    ctl_t ctl_q, ctl_d;

    logic             go;
    logic [NBW-1:0]   nbits;
    logic [15:0]      tx;
    logic             fin;
    logic [15:0]      rx;
    logic             bad_req;
    logic             a8_hit;
    logic [OFS_W-1:0] ofs_nx;
    logic             page_end;
    logic [7:0]       cmd_opc;

    spi_ee_shift #(.DIV(SCK_DIV), .W(16)) u_shift (
        .clk     (clk),
        .rst_n   (rst_n),
        .go_i    (go),
        .nbits_i (nbits),
        .tx_i    (tx),
        .miso_i  (miso_i),
        .fin_o   (fin),
        .rx_o    (rx),
        .sck_o   (sck_o),
        .mosi_o  (mosi_o)
    );

    assign bad_req  = (int'(offset_i) >= WORDS) || (count_i == '0) ||
                      (int'(count_i) > WORDS - int'(offset_i));
    assign a8_hit   = (ADDR_BITS == 8) && (int'(ctl_q.ofs) >= 128);
    assign ofs_nx   = ctl_q.ofs + OFS_W'(1);
    assign page_end = (ofs_nx[PW_BITS-1:0] == '0);
    assign cmd_opc  = (ctl_q.write ? OPC_WRITE : OPC_READ) | (a8_hit ? OPC_A8 : 8'h00);

    always_comb begin
        ctl_d      = ctl_q;
        ctl_d.rvld = 1'b0;
        ctl_d.done = 1'b0;
        go         = 1'b0;
        nbits      = NBW'(OP_BITS);
        tx         = '0;
        wr_take_o  = 1'b0;
        // every shifting state: launch once, then wait for the engine
        if (ctl_q.st inside {S_POLL_OP, S_POLL_IN, S_WREN, S_CMD, S_ADDR, S_DATA} && !ctl_q.sent) begin
            go         = 1'b1;
            ctl_d.sent = 1'b1;
        end
        if (fin) ctl_d.sent = 1'b0;
        unique case (ctl_q.st)
            S_IDLE: if (start_i) begin
                if (bad_req) begin
                    ctl_d.done = 1'b1;
                    ctl_d.err  = 1'b1;
                end else begin
                    ctl_d.err   = 1'b0;
                    ctl_d.write = write_i;
                    ctl_d.ofs   = offset_i;
                    ctl_d.left  = count_i;
                    ctl_d.tries = '0;
                    ctl_d.csn   = 1'b0;
                    ctl_d.st    = S_POLL_OP;
                end
            end
            S_POLL_OP: begin
                tx = 16'(OPC_RDSR);
                if (fin) ctl_d.st = S_POLL_IN;
            end
            S_POLL_IN: begin
                nbits = NBW'(8);
                if (fin) begin
                    ctl_d.csn = 1'b1;
                    ctl_d.gap = '0;
                    if (!rx[0]) begin
                        ctl_d.nxt = ctl_q.write ? S_WREN : S_CMD;
                        ctl_d.st  = S_GAP;
                    end else if (ctl_q.tries == TW'(POLL_MAX - 1)) begin
                        ctl_d.err  = 1'b1;
                        ctl_d.done = 1'b1;
                        ctl_d.st   = S_IDLE;
                    end else begin
                        ctl_d.tries = ctl_q.tries + TW'(1);
                        ctl_d.nxt   = S_POLL_OP;
                        ctl_d.st    = S_GAP;
                    end
                end
            end
            S_GAP: begin
                if (ctl_q.gap == GW'(GAP_CYC - 1)) begin
                    ctl_d.csn = 1'b0;
                    ctl_d.gap = '0;
                    ctl_d.st  = ctl_q.nxt;
                end else begin
                    ctl_d.gap = ctl_q.gap + GW'(1);
                end
            end
            S_WREN: begin
                tx = 16'(OPC_WREN);
                if (fin) begin
                    ctl_d.csn = 1'b1;
                    ctl_d.gap = '0;
                    ctl_d.nxt = S_CMD;
                    ctl_d.st  = S_GAP;
                end
            end
            S_CMD: begin
                tx = 16'(cmd_opc);
                if (fin) ctl_d.st = S_ADDR;
            end
            S_ADDR: begin
                nbits = NBW'(ADDR_BITS);
                tx    = 16'({ctl_q.ofs, 1'b0});
                if (fin) ctl_d.st = S_DATA;
            end
            S_DATA: begin
                nbits     = NBW'(16);
                tx        = ctl_q.write ? {wdata_i[7:0], wdata_i[15:8]} : 16'h0000;
                wr_take_o = ctl_q.write && !ctl_q.sent;
                if (fin) begin
                    if (!ctl_q.write) begin
                        ctl_d.rdata = {rx[7:0], rx[15:8]};
                        ctl_d.rvld  = 1'b1;
                    end
                    ctl_d.ofs  = ofs_nx;
                    ctl_d.left = ctl_q.left - OFS_W'(1);
                    if (ctl_q.left == OFS_W'(1)) begin
                        ctl_d.csn = 1'b1;
                        ctl_d.st  = S_FIN;
                    end else if (ctl_q.write && page_end) begin
                        ctl_d.csn   = 1'b1;
                        ctl_d.tries = '0;
                        ctl_d.gap   = '0;
                        ctl_d.nxt   = S_POLL_OP;
                        ctl_d.st    = S_GAP;
                    end
                end
            end
            S_FIN: begin
                ctl_d.done = 1'b1;
                ctl_d.st   = S_IDLE;
            end
            default: ctl_d.st = S_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_q     <= '0;
            ctl_q.csn <= 1'b1;
        end else begin
            ctl_q <= ctl_d;
        end
    end

    assign cs_n_o      = ctl_q.csn;
    assign rdata_o     = ctl_q.rdata;
    assign rdata_vld_o = ctl_q.rvld;
    assign done_o      = ctl_q.done;
    assign err_o       = ctl_q.err;

    AST_SCK_NEEDS_CS: assert property (@(posedge clk) disable iff (!rst_n)
        sck_o |-> !cs_n_o) else $error("sck high with cs released"); // R5
    AST_MOSI_HOLD_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        (sck_o && $past(sck_o)) |-> $stable(mosi_o)) else $error("mosi moved while sck high"); // R5
    AST_CS_RISE_SCK_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cs_n_o) |-> !sck_o) else $error("cs rose with sck high"); // R12
    AST_DONE_CS_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> cs_n_o) else $error("done while selected"); // R12
    AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o) else $error("done longer than one cycle"); // R12
    AST_TAKE_WRITE_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
        wr_take_o |-> (ctl_q.write && !cs_n_o)) else $error("take outside write"); // R11
    AST_VLD_READ_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
        rdata_vld_o |-> !ctl_q.write) else $error("read strobe during write"); // R8

endmodule

// File: tb/spi_ee_ctl_bench.sv
module spi_ee_ctl_bench;

    localparam int WORDS    = 256;
    localparam int OFS_W    = $clog2(WORDS) + 1;
    localparam int POLL_MAX = 6;
    localparam int BUSY_N   = 2;
    localparam int PG_WORDS = 16;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             start_i = 1'b0;
    logic             write_i = 1'b0;
    logic [OFS_W-1:0] offset_i = '0;
    logic [OFS_W-1:0] count_i = '0;
    logic [15:0]      wdata_i = '0;
    logic             wr_take_o;
    logic [15:0]      rdata_o;
    logic             rdata_vld_o;
    logic             done_o;
    logic             err_o;
    logic             sck_o;
    logic             cs_n_o;
    logic             mosi_o;
    logic             miso_i = 1'b0;

    always #2 clk = ~clk;

    spi_ee_ctl #(
        .WORDS(WORDS), .ADDR_BITS(8), .OP_BITS(8), .PAGE_BYTES(32),
        .SCK_DIV(2), .POLL_MAX(POLL_MAX), .GAP_CYC(3)
    ) u_spi_ee_ctl (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .write_i(write_i),
        .offset_i(offset_i), .count_i(count_i), .wdata_i(wdata_i),
        .wr_take_o(wr_take_o), .rdata_o(rdata_o), .rdata_vld_o(rdata_vld_o),
        .done_o(done_o), .err_o(err_o), .sck_o(sck_o), .cs_n_o(cs_n_o),
        .mosi_o(mosi_o), .miso_i(miso_i)
    );

    int n_chk = 0;
    int n_err = 0;

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s: actual %0d (0x%0h) expected %0d (0x%0h)", req, act, act, exp, exp);
        end
    endtask

    task automatic finish_sim();
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    endtask

    // ---------------- behavioural EEPROM model ----------------
    logic [7:0] mem [512];
    logic [7:0] em  [512];
    logic [7:0] wbuf [32];
    bit         wv   [32];
    int         m_bit, m_mode, m_k, m_busy_left;
    logic [7:0] m_sh, m_op, m_cur, m_stat;
    logic [8:0] m_addr;
    bit         m_wel, m_stuck, m_a8;
    int         n_polls, n_bursts, n_csf, n_proto;
    logic       p_cs = 1'b1, p_sck = 1'b0;

    task automatic m_csfall();
        m_bit = 0; m_mode = 0; n_csf++;
        for (int i = 0; i < 32; i++) wv[i] = 0;
    endtask

    task automatic m_csrise();
        bit any = 0;
        if (m_mode == 5 && m_op == 8'h06) m_wel = 1;
        if (m_op == 8'h05 && m_stat[0] && m_busy_left > 0) m_busy_left--;
        if (m_mode == 3) begin
            for (int i = 0; i < 32; i++) any |= wv[i];
            if (any) begin
                if (m_wel) begin
                    for (int i = 0; i < 32; i++)
                        if (wv[i]) mem[(int'(m_addr) & 9'h1E0) + i] = wbuf[i];
                    m_busy_left = BUSY_N;
                    n_bursts++;
                end else n_proto++;
                m_wel = 0;
            end
        end
        m_mode = 0; m_op = 8'h00;
    endtask

    task automatic m_rise();
        m_sh = {m_sh[6:0], mosi_o};
        m_bit++;
        if (m_mode == 0 && m_bit == 8) begin
            m_op = m_sh; m_bit = 0;
            if (m_sh == 8'h05) begin
                m_stat = {7'b0, (m_stuck || m_busy_left > 0)};
                m_mode = 4; m_k = 0; n_polls++;
            end else begin
                if (m_stuck || m_busy_left > 0) n_proto++;
                if (m_sh == 8'h06) m_mode = 5;
                else if ((m_sh & 8'hF7) == 8'h03 || (m_sh & 8'hF7) == 8'h02) begin
                    m_a8 = m_sh[3]; m_mode = 1;
                end else begin
                    n_proto++; m_mode = 5;
                end
            end
        end else if (m_mode == 1 && m_bit == 8) begin
            m_addr = {m_a8, m_sh}; m_bit = 0;
            if ((m_op & 8'hF7) == 8'h03) begin
                m_mode = 2; m_k = 0; m_cur = mem[m_addr];
            end else m_mode = 3;
        end else if (m_mode == 3 && m_bit == 8) begin
            wbuf[m_addr[4:0]] = m_sh; wv[m_addr[4:0]] = 1;
            m_addr[4:0] = m_addr[4:0] + 5'd1;
            m_bit = 0;
        end
    endtask

    task automatic m_fall();
        if (m_mode == 2) begin
            miso_i = m_cur[7 - m_k]; m_k++;
            if (m_k == 8) begin m_k = 0; m_addr = m_addr + 9'd1; m_cur = mem[m_addr]; end
        end else if (m_mode == 4) begin
            miso_i = m_stat[7 - m_k]; m_k = (m_k + 1) % 8;
        end
    endtask

    initial begin
        forever begin
            @(sck_o or cs_n_o);
            if (cs_n_o && !p_cs) m_csrise();
            else if (!cs_n_o && p_cs) m_csfall();
            if (!cs_n_o && sck_o && !p_sck) m_rise();
            if (!cs_n_o && !sck_o && p_sck) m_fall();
            p_cs = cs_n_o; p_sck = sck_o;
        end
    end

    // ---------------- operation driver ----------------
    logic [15:0] wq [WORDS];
    logic [15:0] rq [WORDS];
    int  got_words, got_takes, got_err, d_polls, d_bursts, d_csf;
    bit  pend = 0;

    function automatic logic [15:0] wpat(input int o, input int k);
        return 16'((o * 131 + k * 7919 + 16'h5A3C) & 16'hFFFF);
    endfunction

    task automatic run(input bit wr, input int o, input int c);
        int  idx = 0, p0 = n_polls, b0 = n_bursts, f0 = n_csf;
        bit  took = 0, fin = 0;
        got_words = 0; got_takes = 0; got_err = 0;
        if (wr) for (int k = 0; k < c && k < WORDS; k++) wq[k] = wpat(o, k);
        wdata_i = wq[0];
        @(negedge clk);
        start_i = 1'b1; write_i = wr; offset_i = OFS_W'(o); count_i = OFS_W'(c);
        for (int cyc = 0; cyc < 60000 && !fin; cyc++) begin
            @(negedge clk);
            start_i = 1'b0;
            if (took) begin idx++; if (idx < WORDS) wdata_i = wq[idx]; end
            took = wr_take_o;
            if (wr_take_o) got_takes++;
            if (rdata_vld_o) begin
                if (got_words < WORDS) rq[got_words] = rdata_o;
                got_words++;
            end
            if (done_o) begin fin = 1; got_err = err_o; end
        end
        check(fin, "R12 operation completes", fin, 1);
        check(cs_n_o === 1'b1 && sck_o === 1'b0, "R12 idle lines after op", {cs_n_o, sck_o}, 2);
        d_polls = n_polls - p0; d_bursts = n_bursts - b0; d_csf = n_csf - f0;
    endtask

    task automatic do_write(input int o, input int c);
        int pages = (o + c - 1) / PG_WORDS - o / PG_WORDS + 1;
        int pr0 = n_proto;
        run(1'b1, o, c);
        check(got_err == 0, "R12 write err flag", got_err, 0);
        check(got_takes == c, "R11 one take per word", got_takes, c);
        check(d_bursts == pages, "R10 page bursts", d_bursts, pages);
        check(d_polls == (pend ? BUSY_N + 1 : 1) + (pages - 1) * (BUSY_N + 1),
              "R3 ready polls before bursts", d_polls,
              (pend ? BUSY_N + 1 : 1) + (pages - 1) * (BUSY_N + 1));
        check(n_proto == pr0, "R9 write enable and busy rules", n_proto - pr0, 0);
        for (int k = 0; k < c; k++) begin
            em[2 * (o + k)]     = wq[k][7:0];
            em[2 * (o + k) + 1] = wq[k][15:8];
        end
        pend = 1;
    endtask

    task automatic do_read(input int o, input int c);
        int bad = 0, first = -1;
        int pr0 = n_proto;
        run(1'b0, o, c);
        check(got_err == 0, "R12 read err flag", got_err, 0);
        check(got_words == c, "R8 word count", got_words, c);
        check(d_polls == (pend ? BUSY_N + 1 : 1), "R3 ready polls before read", d_polls,
              pend ? BUSY_N + 1 : 1);
        check(n_proto == pr0, "R3 no command while busy", n_proto - pr0, 0);
        for (int k = 0; k < c && k < got_words; k++) begin
            logic [15:0] e = {em[2 * (o + k) + 1], em[2 * (o + k)]};
            if (rq[k] !== e) begin bad++; if (first < 0) first = k; end
        end
        if (first >= 0)
            check(0, "R5 R6 R7 R8 read data", int'(rq[first]),
                  int'({em[2 * (o + first) + 1], em[2 * (o + first)]}));
        else
            check(1, "R5 R6 R7 R8 read data", 0, 0);
        pend = 0;
    endtask

    task automatic do_bad(input bit wr, input int o, input int c, input string tag);
        run(wr, o, c);
        check(got_err == 1, {"R2 reject ", tag}, got_err, 1);
        check(d_csf == 0, {"R2 no select ", tag}, d_csf, 0);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        check(0, "watchdog expired", 0, 1);
        finish_sim();
    end

    initial begin
        for (int i = 0; i < 512; i++) begin
            mem[i] = 8'((i * 37 + 11) & 255);
            em[i]  = 8'((i * 37 + 11) & 255);
        end
        m_busy_left = 0; m_wel = 0; m_stuck = 0; m_mode = 0; m_op = 0; m_stat = 0;
        n_polls = 0; n_bursts = 0; n_csf = 0; n_proto = 0;
        repeat (3) @(negedge clk);
        check(cs_n_o === 1'b1, "R1 reset cs_n", cs_n_o, 1);
        check(sck_o === 1'b0 && mosi_o === 1'b0, "R1 reset sck/mosi", {sck_o, mosi_o}, 0);
        check(done_o === 1'b0 && err_o === 1'b0, "R1 reset flags", {done_o, err_o}, 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        do_bad(1'b0, 0, 0, "count zero");
        do_bad(1'b0, 256, 1, "offset past end");
        do_bad(1'b1, 250, 7, "count past end");

        do_read(118, 24);          // crosses byte 256 inside one command
        do_read(200, 10);          // upper half: A8 in opcode (R7)
        do_write(120, 20);         // page split at 128 and A8 switch (R10, R7)
        do_read(118, 24);
        for (int o = 0; o < WORDS; o += 23) begin
            int c = (o % 19) + 1;
            if (c > WORDS - o) c = WORDS - o;
            do_write(o, c);
        end
        do_write(250, 6);
        do_write(255, 1);
        do_write(143, 33);         // three pages, starts mid page

        m_stuck = 1;
        run(1'b0, 10, 4);
        check(got_err == 1, "R4 status timeout error", got_err, 1);
        check(d_polls == POLL_MAX, "R4 poll count at timeout", d_polls, POLL_MAX);
        check(got_words == 0, "R4 no data after timeout", got_words, 0);
        m_stuck = 0;
        pend = 0;

        do_read(0, 256);
        begin
            int bad = 0, first = -1;
            for (int i = 0; i < 512; i++)
                if (mem[i] !== em[i]) begin bad++; if (first < 0) first = i; end
            check(bad == 0, "R11 stored byte order", first, -1);
        end
        finish_sim();
    end

endmodule